// File: doc/BRIEF.md
# Serial Receive FIFO with Fill Trigger and Idle Timeout

This block buffers bytes coming out of a serial receiver until host software drains them. Bytes arrive on a single-cycle valid strobe and are kept in a 16-entry circular store. A host read strobe removes the oldest byte and returns it on the data output. The number of bytes currently held is always visible on a count output.

Software picks a fill threshold of 1, 4, 8 or 14 bytes. The block raises a data-ready flag, and a receive interrupt request when interrupts are enabled, once the stored count reaches that threshold. Some data can stay below the threshold for a long time. For that case an idle timer runs for 15 bit periods after each byte that leaves the count short of the threshold. When the timer runs out, the block raises the same flag and request. A write to the FIFO control input selects the threshold and can also empty the store.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the count is 0, the data-ready flag, interrupt request and overrun are low, the read data output is 0 and the threshold is 1 byte.
- R2: Bytes leave in the order they arrived, across pointer wrap-around; the read data output shows the byte one cycle after the read strobe and holds it until the next read.
- R3: The count output equals bytes accepted minus bytes read, never exceeds 16, and a push and a read in the same cycle leave it unchanged.
- R4: A read while the store is empty returns 0 and leaves the count at 0.
- R5: FIFO-control bits 7:6 select the threshold (code 0 = 1 byte, 1 = 4, 2 = 8, 3 = 14); an accepted byte that brings the count to the threshold or above sets the data-ready flag on the next cycle.
- R6: A read that leaves the count below the threshold clears the data-ready flag and the interrupt request; a read that leaves it at or above the threshold keeps both set.
- R7: The interrupt request is set together with the flag only while the interrupt-enable input is high; deasserting that input clears the request on the next cycle.
- R8: An accepted byte that leaves the count below the threshold restarts an idle timer of 15 × ETU_CYCLES cycles; when it expires the flag, and the request if enabled, go high exactly that many cycles after the last such byte.
- R9: An accepted byte that brings the count to the threshold cancels a running idle timer; reads never restart it.
- R10: While the receive-enable input is low, incoming bytes are ignored.
- R11: A byte arriving while 16 bytes are stored is dropped, the contents are unchanged and the overrun output pulses high for exactly one cycle.
- R12: A FIFO-control write with bit 1 set empties the store, clears the flag and the request, and cancels the idle timer; a write with bit 1 clear only changes the threshold and keeps the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_en | input | 1 | Receive enable; bytes are accepted only while high |
| rxint_en | input | 1 | Receive interrupt enable |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| fctl_wr | input | 1 | FIFO-control write strobe |
| fctl_data | input | 8 | FIFO-control value: bits 7:6 threshold code, bit 1 flush |
| rd_req | input | 1 | Host read strobe for the receive data |
| rd_data | output | 8 | Byte returned by the last read (0 if the read found the store empty) |
| fill_count | output | 5 | Number of bytes stored |
| rx_full | output | 1 | Data-ready flag |
| rx_irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | One-cycle pulse when a byte is dropped on a full store |

## Verification
The bench sweeps every threshold code. After each byte it checks the count and the flag, so a decoder that maps a code to the wrong level sets the flag one byte early or late. It fills all 16 entries across the pointer wrap and pushes one more byte. A design that overwrote the oldest entry, or let the count reach 17, would return the wrong byte sequence or a wrong count.

The idle timer is checked to the exact cycle, both after a single byte and after a second byte that restarts it. An off-by-one load value, or a timer that a new byte does not restart, fires a cycle early or late. The bench also drains the store below the threshold after the threshold was reached and waits longer than the timeout. A timer that the threshold byte failed to cancel would then raise the flag.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Number of threshold codes carried by the FIFO-control word.
  localparam int unsigned TRIG_CODES = 4;

  // Threshold code to fill level.
  function automatic logic [7:0] trig_level(input logic [1:0] code);
    logic [7:0] lvl;
    unique case (code)
      2'd0:    lvl = 8'd1;
      2'd1:    lvl = 8'd4;
      2'd2:    lvl = 8'd8;
      default: lvl = 8'd14;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, wptr_inc;
  logic [PW-1:0] rptr_q, rptr_d, rptr_inc;
  logic [CW-1:0] cnt_q,  cnt_d;

  // Pointer advance: free wrap for a power-of-two depth, compare otherwise.
  generate
    if (POW2) begin : g_wrap_free
      always_comb begin
        wptr_inc = wptr_q + PW'(1);
        rptr_inc = rptr_q + PW'(1);
      end
    end else begin : g_wrap_cmp
      always_comb begin
        wptr_inc = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
        rptr_inc = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
      end
    end
  endgenerate

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = wptr_inc;
      if (pop)  rptr_d = rptr_inc;
      cnt_d = cnt_q + {{(CW-1){1'b0}}, push} - {{(CW-1){1'b0}}, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Storage carries no reset; an entry is only read after it was written.
  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (push && !flush && (wptr_q == PW'(i))) mem[i] <= wdata;
    end
  end

  assign head_data = mem[rptr_q];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R3
  AST_NO_PUSH_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH))); // R11
  AST_NO_POP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout #(
  parameter int unsigned ETU_CYCLES = 4,
  parameter int unsigned TMO_UNITS  = 15,
  localparam int unsigned LOAD      = ETU_CYCLES * TMO_UNITS,
  localparam int unsigned TW        = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cancel,
  output logic expire
);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    expire = (tmr_q == TW'(1)) && !restart && !cancel;
    if (cancel)              tmr_d = '0;
    else if (restart)        tmr_d = TW'(LOAD);
    else if (tmr_q != '0)    tmr_d = tmr_q - TW'(1);
    else                     tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  AST_TMR_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == '0) && !restart |=> (tmr_q == '0)); // R9
  AST_TMR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !expire); // R9

endmodule

// File: rtl/rxf_status.sv
module rxf_status #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] count_nxt,
  input  logic [CW-1:0] trig,
  input  logic          expire,
  input  logic          ie,
  output logic          full,
  output logic          irq
);

  logic full_q, full_d, irq_q, irq_d;
  logic reach, drain;

  always_comb begin
    reach = push && (count_nxt >= trig);
    drain = pop && !push && (count_nxt < trig);

    full_d = full_q;
    if (flush)                full_d = 1'b0;
    else if (reach || expire) full_d = 1'b1;
    else if (drain)           full_d = 1'b0;

    irq_d = irq_q;
    if (flush || !ie)         irq_d = 1'b0;
    else if (reach || expire) irq_d = 1'b1;
    else if (drain)           irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      irq_q  <= irq_d;
    end
  end

  assign full = full_q;
  assign irq  = irq_q;

  AST_FULL_AT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush && (count_nxt >= trig) |=> full_q); // R5
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !flush |=> full_q); // R8
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie)); // R7
  AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> full_q); // R6

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int unsigned DW         = 8,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned ETU_CYCLES = 4,
  parameter int unsigned TMO_UNITS  = 15,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rxint_en,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          fctl_wr,
  input  logic [7:0]    fctl_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] fill_count,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          overrun
);

  import rxf_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          flush, push_ok, pop_ok, drop;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [CW-1:0] trig_q, trig_d;
  logic [DW-1:0] head_data;
  logic [DW-1:0] rdat_q, rdat_d;
  logic          ovr_q, ovr_d;
  logic          tmr_restart, tmr_cancel, tmr_expire;

  // Request qualification.
  always_comb begin
    flush       = fctl_wr && fctl_data[1];
    push_ok     = rx_valid && rx_en && !flush && (cnt != FULL_CNT);
    drop        = rx_valid && rx_en && !flush && (cnt == FULL_CNT);
    pop_ok      = rd_req && !flush && (cnt != '0);
    tmr_restart = push_ok && (cnt_nxt < trig_q);
    tmr_cancel  = flush || (push_ok && (cnt_nxt >= trig_q));
  end

  // Next-state for top-level registers.
  always_comb begin
    trig_d = trig_q;
    if (fctl_wr) trig_d = CW'(trig_level(fctl_data[7:6]));
    rdat_d = rdat_q;
    if (rd_req) rdat_d = pop_ok ? head_data : '0;
    ovr_d = drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= CW'(1);
      rdat_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      trig_q <= trig_d;
      rdat_q <= rdat_d;
      ovr_q  <= ovr_d;
    end
  end

  rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push_ok),
    .pop       (pop_ok),
    .wdata     (rx_byte),
    .head_data (head_data),
    .count     (cnt),
    .count_nxt (cnt_nxt)
  );

  rxf_timeout #(.ETU_CYCLES(ETU_CYCLES), .TMO_UNITS(TMO_UNITS)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .cancel  (tmr_cancel),
    .expire  (tmr_expire)
  );

  rxf_status #(.CW(CW)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (push_ok),
    .pop       (pop_ok),
    .count_nxt (cnt_nxt),
    .trig      (trig_q),
    .expire    (tmr_expire),
    .ie        (rxint_en),
    .full      (rx_full),
    .irq       (rx_irq)
  );

  assign rd_data    = rdat_q;
  assign fill_count = cnt;
  assign overrun    = ovr_q;

  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(fill_count == FULL_CNT)); // R11
  AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !drop |=> !overrun); // R11
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && (fill_count == '0) |=> (rd_data == '0)); // R4
  AST_RXEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rd_req && !fctl_wr |=> $stable(fill_count)); // R10

endmodule

// File: tb/rx_trig_fifo_tb.sv
module rx_trig_fifo_tb;

  localparam int ETU = 2;
  localparam int T   = 15 * ETU;

  logic       clk;
  logic       rst_n;
  logic       rx_en, rxint_en, rx_valid, fctl_wr, rd_req;
  logic [7:0] rx_byte, fctl_data, rd_data;
  logic [4:0] fill_count;
  logic       rx_full, rx_irq, overrun;

  int checks;
  int failures;

  rx_trig_fifo #(.ETU_CYCLES(ETU)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxint_en(rxint_en),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .fctl_wr(fctl_wr),
    .fctl_data(fctl_data), .rd_req(rd_req), .rd_data(rd_data),
    .fill_count(fill_count), .rx_full(rx_full), .rx_irq(rx_irq),
    .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; b = rd_data;
  endtask

  task automatic fctl(input logic [7:0] v);
    @(negedge clk); fctl_wr = 1'b1; fctl_data = v;
    @(negedge clk); fctl_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int lvl [4];
    int bad;
    lvl[0] = 1; lvl[1] = 4; lvl[2] = 8; lvl[3] = 14;
    checks = 0; failures = 0;
    rst_n = 1'b0; rx_en = 1'b1; rxint_en = 1'b1; rx_valid = 1'b0;
    rx_byte = '0; fctl_wr = 1'b0; fctl_data = '0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", fill_count, 0);
    chk("R1 full", rx_full, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rd_data", rd_data, 0);
    push(8'h77);
    chk("R1 threshold one", rx_full, 1);
    fctl(8'h02);

    // R5 R6 R2 sweep of every threshold code
    for (int c = 0; c < 4; c++) begin
      fctl(8'((c << 6) | 2));
      for (int i = 0; i < lvl[c]; i++) begin
        push(8'(c * 16 + i + 1));
        chk("R3 count on push", fill_count, i + 1);
        chk("R5 full vs threshold", rx_full, int'(i + 1 >= lvl[c]));
        chk("R7 irq vs threshold", rx_irq, int'(i + 1 >= lvl[c]));
      end
      for (int i = 0; i < lvl[c]; i++) begin
        pop(b);
        chk("R2 order", b, c * 16 + i + 1);
        chk("R6 full after read", rx_full, 0);
        chk("R6 irq after read", rx_irq, 0);
      end
      chk("R3 drained", fill_count, 0);
    end

    // R11 R2 R6 full store, overrun, wrap
    fctl(8'hC2);
    for (int i = 0; i < 16; i++) push(8'(8'hA0 + i));
    chk("R3 count full", fill_count, 16);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h55;
    @(negedge clk); rx_valid = 1'b0;
    chk("R11 overrun pulse", overrun, 1);
    chk("R11 count unchanged", fill_count, 16);
    @(negedge clk);
    chk("R11 overrun one cycle", overrun, 0);
    for (int i = 0; i < 16; i++) begin
      pop(b);
      chk("R2 order after wrap", b, 8'hA0 + i);
      chk("R6 full above threshold", rx_full, int'(15 - i >= 14));
      chk("R6 irq above threshold", rx_irq, int'(15 - i >= 14));
    end

    // R4 empty read
    chk("R2 hold last byte", rd_data, 8'hAF);
    pop(b);
    chk("R4 empty read data", b, 0);
    chk("R4 empty count", fill_count, 0);

    // R3 simultaneous push and read
    push(8'h3C);
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h4D; rd_req = 1'b1;
    @(negedge clk); rx_valid = 1'b0; rd_req = 1'b0;
    chk("R3 push+read count", fill_count, 1);
    chk("R2 push+read data", rd_data, 8'h3C);
    pop(b);
    chk("R2 second byte", b, 8'h4D);
    fctl(8'h02);

    // R8 timeout from a single byte
    fctl(8'h42);
    push(8'h11);
    bad = 0;
    for (int j = 1; j < T; j++) begin
      @(negedge clk);
      if (rx_full) bad++;
    end
    chk("R8 flag low before expiry", bad, 0);
    @(negedge clk);
    chk("R8 flag at expiry", rx_full, 1);
    chk("R8 irq at expiry", rx_irq, 1);
    fctl(8'h42);

    // R8 restart by a second byte
    push(8'h12);
    repeat (20) @(negedge clk);
    push(8'h13);
    bad = 0;
    for (int j = 1; j < T; j++) begin
      @(negedge clk);
      if (rx_full) bad++;
    end
    chk("R8 restart keeps flag low", bad, 0);
    @(negedge clk);
    chk("R8 flag after restart", rx_full, 1);
    fctl(8'h42);

    // R9 threshold byte cancels timer
    for (int i = 0; i < 4; i++) push(8'(8'h20 + i));
    chk("R9 full at threshold", rx_full, 1);
    pop(b);
    chk("R6 cleared below threshold", rx_full, 0);
    repeat (T + 5) @(negedge clk);
    chk("R9 no late timeout", rx_full, 0);
    chk("R9 no late irq", rx_irq, 0);
    fctl(8'h02);

    // R7 interrupt enable gating
    rxint_en = 1'b0;
    push(8'h31);
    chk("R7 full without enable", rx_full, 1);
    chk("R7 irq masked", rx_irq, 0);
    fctl(8'h02);
    rxint_en = 1'b1;
    push(8'h32);
    chk("R7 irq enabled", rx_irq, 1);
    @(negedge clk); rxint_en = 1'b0;
    @(negedge clk);
    chk("R7 irq dropped", rx_irq, 0);
    rxint_en = 1'b1;
    fctl(8'h02);

    // R10 receive disabled
    rx_en = 1'b0;
    push(8'h66);
    chk("R10 ignored count", fill_count, 0);
    chk("R10 ignored flag", rx_full, 0);
    rx_en = 1'b1;

    // R12 flush behaviour
    fctl(8'h42);
    for (int i = 0; i < 5; i++) push(8'(8'h40 + i));
    fctl(8'h40);
    chk("R12 no flush keeps data", fill_count, 5);
    fctl(8'h42);
    chk("R12 flush count", fill_count, 0);
    chk("R12 flush full", rx_full, 0);
    chk("R12 flush irq", rx_irq, 0);
    push(8'h50);
    fctl(8'h42);
    repeat (T + 3) @(negedge clk);
    chk("R12 flush cancels timer", rx_full, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule